// File: doc/BRIEF.md
# Control Register with Synchronized Enable and Soft Reset

This block is the bus-side control register of a serial peripheral. Software reaches it over an APB-style port. It holds an enable bit, a soft-reset bit, a debug-control register and a set of plain configuration bits. Enable and soft-reset changes are carried into the peripheral clock domain by a toggle-and-acknowledge handshake. Progress is reported through self-clearing busy flags in a separate status register.

A soft reset takes priority over everything else in the same write. It is only honoured while the peripheral is enabled. Until the peripheral domain acknowledges it, every register write is refused with a slave error, and reads return reset values. The serial protocol engine sits outside this block. It sees the control word, the debug bits, a mode decode, and the `syncEnable` / `syncReset` levels qualified by `reqToggle`. It answers by mirroring `reqToggle` on `ackToggle`.

Top module: `ctrl_sync_regs`

## Requirements
- R1: After reset, the control register (offset 0x0), the busy register (offset 0x4) and the debug register (offset 0x8) all read 0, and `cfgOut`, `syncEnable` and `syncReset` are 0.
- R2: In the control register, bit 1 is enable and bit 0 is soft reset. A write to offset 0x0 that does not start a soft reset shows the written enable value on the very next read. The same write sets busy bit 1 (enable busy). Busy bit 1 clears when the peripheral acknowledges the handshake launched for that write.
- R3: A handshake is launched one cycle after the write. With an acknowledge path of D cycles and two synchronizer stages, enable busy clears D+3 cycles after the launch.
- R4: The configuration bits (mask `CFG_MASK`, excluding bits 1:0) take a written value only while enable currently reads 0. While enable reads 1 they keep their value, and the write raises no slave error.
- R5: A write with bit 0 set while enable reads 1 starts a soft reset, and all other bits of that write are discarded. Until completion, the control register reads 0x1, the busy register reads 0x1 (bit 0 is reset busy), and `syncReset` is 1 after launch.
- R6: Any write while a soft reset is in progress asserts `pslverr` in its access cycle and changes no register.
- R7: While a soft reset is in progress, the debug register reads 0, and any unmapped offset reads 0.
- R8: When the soft reset is acknowledged, the control and busy registers return to 0 in the same cycle. The debug register keeps its value.
- R9: A write with bit 0 set while enable reads 0 starts no soft reset. The other bits are written as an ordinary write, including setting enable busy.
- R10: `i2cClientSel` is 1 exactly when the mode field, bits 4:2 of the control register, holds 4.
- R11: A control write made while a handshake is outstanding keeps enable busy set after that handshake completes. A second handshake is launched, and busy clears only when that second handshake is acknowledged.
- R12: `syncEnable` and `syncReset` do not change while a handshake is outstanding. `reqToggle` changes only when a launch happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | ADDR_W | APB byte offset |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pslverr | output | 1 | Slave error for writes during soft reset |
| cfgOut | output | 32 | Current control word to the peripheral |
| dbgOut | output | DBG_W | Debug-control bits |
| i2cClientSel | output | 1 | Mode field decodes to I2C client |
| syncEnable | output | 1 | Enable level carried by the handshake |
| syncReset | output | 1 | Soft-reset level carried by the handshake |
| reqToggle | output | 1 | Request toggle to the peripheral domain |
| ackToggle | input | 1 | Acknowledge toggle from the peripheral domain |

## Verification
The assertions check four things on every cycle:
- the configuration bits never move while the block is enabled and not resetting;
- a write refused during reset leaves the debug bits alone;
- the control word sits at 0x1 throughout a reset and is 0 when the reset ends;
- the handshake levels and the toggle change only at a launch.

Other behaviours need the bench's scenarios and its cycle-level reference model:
- the exact cycle in which each busy flag clears;
- the relaunch after a write that lands mid-handshake;
- the discarding of the other bits in a soft-reset write;
- the masked read values during reset;
- the retained debug value afterwards.

// File: rtl/ctrl_sync_regs_pkg.sv
package ctrl_sync_regs_pkg;
  localparam int OFS_CTRL = 0;
  localparam int OFS_BUSY = 4;
  localparam int OFS_DBG  = 8;
  localparam int RST_BIT  = 0;
  localparam int EN_BIT   = 1;

  typedef struct packed {
    logic wrCtrl;
    logic rstStart;
    logic wrDbg;
    logic rstDone;
    logic clrEnBusy;
  } ctlStrobes_t;

  typedef enum logic {ST_IDLE = 1'b0, ST_WAIT = 1'b1} hsState_t;
endpackage

// File: rtl/ctrl_sync_regs_sync.sv
module ctrl_sync_regs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain[0] <= 1'b0;
    else       chain[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain[i] <= 1'b0;
      else       chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/ctrl_sync_regs_ctl.sv
module ctrl_sync_regs_ctl
  import ctrl_sync_regs_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic              wrRstBit,
  input  logic              enableQ,
  input  logic              rstBusyQ,
  input  logic              ackToggle,
  output ctlStrobes_t       strb,
  output logic              pslverr,
  output logic              reqToggle,
  output logic              syncEnable,
  output logic              syncReset,
  output logic              waiting,
  output logic              dirty
);
  hsState_t state;
  logic     ackSynced;
  logic     wrAcc;
  logic     hitCtrl;
  logic     hitDbg;
  logic     rstReq;
  logic     launch;
  logic     doneNow;

  ctrl_sync_regs_sync #(.STAGES(SYNC_STAGES)) u_ackSync (
    .clk (clk),
    .rstN(rstN),
    .d   (ackToggle),
    .q   (ackSynced)
  );

  assign wrAcc   = psel && penable && pwrite;
  assign hitCtrl = (paddr == ADDR_W'(OFS_CTRL));
  assign hitDbg  = (paddr == ADDR_W'(OFS_DBG));
  assign rstReq  = wrRstBit && enableQ;

  assign launch  = (state == ST_IDLE) && dirty;
  assign doneNow = (state == ST_WAIT) && (reqToggle == ackSynced);
  assign waiting = (state == ST_WAIT);

  always_comb begin
    strb.wrCtrl    = wrAcc && hitCtrl && !rstBusyQ && !rstReq;
    strb.rstStart  = wrAcc && hitCtrl && !rstBusyQ && rstReq;
    strb.wrDbg     = wrAcc && hitDbg && !rstBusyQ;
    strb.rstDone   = doneNow && syncReset;
    strb.clrEnBusy = doneNow && !syncReset && !dirty;
  end

  assign pslverr = wrAcc && rstBusyQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      dirty      <= 1'b0;
      reqToggle  <= 1'b0;
      syncEnable <= 1'b0;
      syncReset  <= 1'b0;
    end else begin
      if (launch) begin
        state      <= ST_WAIT;
        reqToggle  <= ~reqToggle;
        syncEnable <= enableQ;
        syncReset  <= rstBusyQ;
      end else if (doneNow) begin
        state <= ST_IDLE;
      end

      if (strb.rstDone)                     dirty <= 1'b0;
      else if (strb.wrCtrl || strb.rstStart) dirty <= 1'b1;
      else if (launch)                      dirty <= 1'b0;
    end
  end
endmodule

// File: rtl/ctrl_sync_regs_dp.sv
module ctrl_sync_regs_dp
  import ctrl_sync_regs_pkg::*;
#(
  parameter int          ADDR_W   = 12,
  parameter int          DBG_W    = 1,
  parameter logic [31:0] CFG_MASK = 32'hFFFF_009C
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strb,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic [31:0]       ctrlQ,
  output logic [DBG_W-1:0]  dbgQ,
  output logic              enBusyQ,
  output logic              rstBusyQ
);
  localparam logic [31:0] CFG_ONLY = CFG_MASK & ~32'h3;
  localparam logic [31:0] RST_WORD = 32'h1 << RST_BIT;

  logic [31:0] nextCtrl;

  always_comb begin
    nextCtrl = (ctrlQ[EN_BIT] ? ctrlQ : pwdata) & CFG_ONLY;
    nextCtrl[EN_BIT] = pwdata[EN_BIT];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ    <= '0;
      dbgQ     <= '0;
      enBusyQ  <= 1'b0;
      rstBusyQ <= 1'b0;
    end else begin
      if (strb.rstDone)       ctrlQ <= '0;
      else if (strb.rstStart) ctrlQ <= RST_WORD;
      else if (strb.wrCtrl)   ctrlQ <= nextCtrl;

      if (strb.wrDbg) dbgQ <= pwdata[DBG_W-1:0];

      if (strb.rstDone)        enBusyQ <= 1'b0;
      else if (strb.wrCtrl)    enBusyQ <= 1'b1;
      else if (strb.clrEnBusy) enBusyQ <= 1'b0;

      if (strb.rstStart)     rstBusyQ <= 1'b1;
      else if (strb.rstDone) rstBusyQ <= 1'b0;
    end
  end

  always_comb begin
    prdata = '0;
    if (paddr == ADDR_W'(OFS_CTRL)) begin
      prdata = ctrlQ;
    end else if (paddr == ADDR_W'(OFS_BUSY)) begin
      prdata[RST_BIT] = rstBusyQ;
      prdata[EN_BIT]  = enBusyQ && !rstBusyQ;
    end else if (paddr == ADDR_W'(OFS_DBG)) begin
      prdata[DBG_W-1:0] = rstBusyQ ? '0 : dbgQ;
    end
  end
endmodule

// File: rtl/ctrl_sync_regs.sv
module ctrl_sync_regs
  import ctrl_sync_regs_pkg::*;
#(
  parameter int          ADDR_W      = 12,
  parameter int          DBG_W       = 1,
  parameter int          SYNC_STAGES = 2,
  parameter int          MODE_LSB    = 2,
  parameter int          MODE_W      = 3,
  parameter int          MODE_I2C    = 4,
  parameter logic [31:0] CFG_MASK    = 32'hFFFF_009C
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic              pslverr,
  output logic [31:0]       cfgOut,
  output logic [DBG_W-1:0]  dbgOut,
  output logic              i2cClientSel,
  output logic              syncEnable,
  output logic              syncReset,
  output logic              reqToggle,
  input  logic              ackToggle
);
  ctlStrobes_t      strb;
  logic [31:0]      ctrlQ;
  logic [DBG_W-1:0] dbgQ;
  logic             enBusyQ;
  logic             rstBusyQ;
  logic             waiting;
  logic             dirty;

  ctrl_sync_regs_ctl #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .psel      (psel),
    .penable   (penable),
    .pwrite    (pwrite),
    .paddr     (paddr),
    .wrRstBit  (pwdata[RST_BIT]),
    .enableQ   (ctrlQ[EN_BIT]),
    .rstBusyQ  (rstBusyQ),
    .ackToggle (ackToggle),
    .strb      (strb),
    .pslverr   (pslverr),
    .reqToggle (reqToggle),
    .syncEnable(syncEnable),
    .syncReset (syncReset),
    .waiting   (waiting),
    .dirty     (dirty)
  );

  ctrl_sync_regs_dp #(.ADDR_W(ADDR_W), .DBG_W(DBG_W), .CFG_MASK(CFG_MASK)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .paddr   (paddr),
    .pwdata  (pwdata),
    .prdata  (prdata),
    .ctrlQ   (ctrlQ),
    .dbgQ    (dbgQ),
    .enBusyQ (enBusyQ),
    .rstBusyQ(rstBusyQ)
  );

  assign cfgOut       = ctrlQ;
  assign dbgOut       = dbgQ;
  assign i2cClientSel = (ctrlQ[MODE_LSB +: MODE_W] == MODE_W'(MODE_I2C));
endmodule

// File: rtl/ctrl_sync_regs_chk.sv
module ctrl_sync_regs_chk #(
  parameter int          DBG_W    = 1,
  parameter logic [31:0] CFG_MASK = 32'hFFFF_009C
) (
  input logic             clk,
  input logic             rstN,
  input logic             psel,
  input logic             penable,
  input logic             pwrite,
  input logic [31:0]      ctrlQ,
  input logic [DBG_W-1:0] dbgQ,
  input logic             rstBusyQ,
  input logic             waiting,
  input logic             dirty,
  input logic             reqToggle,
  input logic             syncEnable,
  input logic             syncReset
);
  localparam logic [31:0] CFG_ONLY = CFG_MASK & ~32'h3;

  AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlQ[1] && !rstBusyQ) |=> (rstBusyQ || ((ctrlQ & CFG_ONLY) == ($past(ctrlQ) & CFG_ONLY)))); // R4

  AST_RST_CTRL_HELD: assert property (@(posedge clk) disable iff (!rstN)
    rstBusyQ |-> (ctrlQ == 32'h1)); // R5

  AST_REFUSED_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (psel && penable && pwrite && rstBusyQ) |=> $stable(dbgQ)); // R6

  AST_RST_END_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rstBusyQ) |-> (ctrlQ == 32'h0)); // R8

  AST_LEVELS_HELD: assert property (@(posedge clk) disable iff (!rstN)
    waiting |=> ($stable(syncEnable) && $stable(syncReset))); // R12

  AST_TOGGLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!waiting && !dirty) |=> $stable(reqToggle)); // R12
endmodule

bind ctrl_sync_regs ctrl_sync_regs_chk #(.DBG_W(DBG_W), .CFG_MASK(CFG_MASK)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .psel      (psel),
  .penable   (penable),
  .pwrite    (pwrite),
  .ctrlQ     (ctrlQ),
  .dbgQ      (dbgQ),
  .rstBusyQ  (rstBusyQ),
  .waiting   (waiting),
  .dirty     (dirty),
  .reqToggle (reqToggle),
  .syncEnable(syncEnable),
  .syncReset (syncReset)
);

// File: tb/ctrl_sync_regs_test.sv
`timescale 1ns/1ps
module ctrl_sync_regs_test;
  localparam int ACK_DLY = 10;
  localparam int LAT     = ACK_DLY + 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata, cfgOut;
  logic        pslverr, i2cClientSel, syncEnable, syncReset, reqToggle;
  logic [0:0]  dbgOut;
  logic [ACK_DLY-1:0] ackPipe = '0;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  ctrl_sync_regs uut (
    .clk(clk), .rstN(rstN), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pslverr(pslverr),
    .cfgOut(cfgOut), .dbgOut(dbgOut), .i2cClientSel(i2cClientSel),
    .syncEnable(syncEnable), .syncReset(syncReset), .reqToggle(reqToggle),
    .ackToggle(ackPipe[ACK_DLY-1])
  );

  // peripheral side: echoes the request toggle after ACK_DLY cycles
  always @(posedge clk) ackPipe <= {ackPipe[ACK_DLY-2:0], reqToggle};

  // behavioural reference model
  logic [31:0] mCtrl = '0;
  logic        mDbg = 1'b0;
  bit mEnBusy, mRstBusy, mDirty, mWait, mSentEn, mSentRst;
  int mCnt;

  always @(posedge clk) begin
    bit wr, hitCtrl, rstStart, wrCtrl, wrDbg, done, launch, rstDone, clrBusy;
    if (!rstN) begin
      mCtrl = '0; mDbg = 1'b0; mEnBusy = 0; mRstBusy = 0; mDirty = 0;
      mWait = 0; mSentEn = 0; mSentRst = 0; mCnt = 0;
    end else begin
      wr       = psel && penable && pwrite;
      hitCtrl  = (paddr == 12'h0);
      rstStart = wr && hitCtrl && !mRstBusy && pwdata[0] && mCtrl[1];
      wrCtrl   = wr && hitCtrl && !mRstBusy && !(pwdata[0] && mCtrl[1]);
      wrDbg    = wr && (paddr == 12'h8) && !mRstBusy;
      done     = mWait && (mCnt == 1);
      launch   = !mWait && mDirty;
      rstDone  = done && mSentRst;
      clrBusy  = done && !mSentRst && !mDirty;
      if (mWait) mCnt--;
      if (launch) begin
        mWait = 1; mCnt = LAT; mSentEn = mCtrl[1]; mSentRst = mRstBusy;
      end else if (done) mWait = 0;
      if (rstDone) mDirty = 0;
      else if (wrCtrl || rstStart) mDirty = 1;
      else if (launch) mDirty = 0;
      if (rstDone) begin
        mCtrl = '0; mEnBusy = 0; mRstBusy = 0;
      end else if (rstStart) begin
        mCtrl = 32'h1; mRstBusy = 1;
      end else if (wrCtrl) begin
        if (!mCtrl[1]) mCtrl = pwdata & 32'hFFFF_009C;
        mCtrl[1] = pwdata[1];
        mEnBusy = 1;
      end else if (clrBusy) mEnBusy = 0;
      if (wrDbg) mDbg = pwdata[0];
    end
  end

  function automatic logic [31:0] modelRead(logic [11:0] a);
    if (a == 12'h0) return mCtrl;
    if (a == 12'h4) return mRstBusy ? 32'h1 : {30'd0, mEnBusy, 1'b0};
    if (a == 12'h8) return mRstBusy ? 32'h0 : {31'd0, mDbg};
    return 32'h0;
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !finished) begin
      check("R2 R5 R8 model cfgOut", cfgOut, mCtrl);
      check("R7 model prdata", prdata, modelRead(paddr));
      check("R6 model pslverr", {31'd0, pslverr}, {31'd0, psel && penable && pwrite && mRstBusy});
      check("R10 model i2cClientSel", {31'd0, i2cClientSel}, {31'd0, mCtrl[4:2] == 3'd4});
      check("R12 model syncEnable", {31'd0, syncEnable}, {31'd0, mSentEn});
      check("R5 model syncReset", {31'd0, syncReset}, {31'd0, mSentRst});
      check("R8 model dbgOut", {31'd0, dbgOut}, {31'd0, mDbg});
    end
  end

  // tasks start and end at a falling edge
  task automatic apbWrite(logic [11:0] a, logic [31:0] d, output logic err);
    psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(posedge clk); @(negedge clk);
    penable = 1;
    #1 err = pslverr;
    @(posedge clk); @(negedge clk);
    psel = 0; penable = 0; pwrite = 0; paddr = '0;
  endtask

  task automatic apbRead(logic [11:0] a, output logic [31:0] d);
    psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(posedge clk); @(negedge clk);
    penable = 1;
    #1 d = prdata;
    @(posedge clk); @(negedge clk);
    psel = 0; penable = 0; paddr = '0;
  endtask

  task automatic waitCycles(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finishRun();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

  initial begin
    logic [31:0] rd;
    logic        err;
    repeat (5) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R1: reset state
    apbRead(12'h0, rd); check("R1 ctrl reset", rd, 32'h0);
    apbRead(12'h4, rd); check("R1 busy reset", rd, 32'h0);
    apbRead(12'h8, rd); check("R1 dbg reset", rd, 32'h0);
    check("R1 cfgOut reset", cfgOut, 32'h0);

    // R4 R10: configure while disabled, mode 4
    apbWrite(12'h0, 32'h0001_0090, err);
    check("R4 no error", {31'd0, err}, 32'h0);
    apbRead(12'h0, rd); check("R4 cfg written while disabled", rd, 32'h0001_0090);
    check("R10 mode 4 selects client", {31'd0, i2cClientSel}, 32'h1);
    apbRead(12'h4, rd); check("R2 busy set on write", rd, 32'h2);
    waitCycles(20);
    apbRead(12'h4, rd); check("R3 busy cleared", rd, 32'h0);

    apbWrite(12'h8, 32'h1, err);

    // R2 R12: enable
    apbWrite(12'h0, 32'h0001_0092, err);
    apbRead(12'h0, rd); check("R2 enable reads back at once", rd, 32'h0001_0092);
    waitCycles(20);
    check("R12 syncEnable carried", {31'd0, syncEnable}, 32'h1);

    // R4: protected write while enabled
    apbWrite(12'h0, 32'h0000_0006, err);
    check("R4 protected write no error", {31'd0, err}, 32'h0);
    apbRead(12'h0, rd); check("R4 cfg kept while enabled", rd, 32'h0001_0092);
    check("R10 mode unchanged", {31'd0, i2cClientSel}, 32'h1);
    waitCycles(20);

    // R11: write while a handshake is outstanding
    apbWrite(12'h0, 32'h0001_0090, err);
    apbWrite(12'h0, 32'h0001_0092, err);
    waitCycles(10);
    apbRead(12'h4, rd); check("R11 busy held for relaunch", rd, 32'h2);
    waitCycles(30);
    apbRead(12'h4, rd); check("R11 busy cleared after second", rd, 32'h0);

    // R5 R6 R7 R8: soft reset with precedence
    apbWrite(12'h0, 32'hFFFF_FFFF, err);
    check("R5 reset write no error", {31'd0, err}, 32'h0);
    apbRead(12'h0, rd); check("R5 ctrl during reset", rd, 32'h1);
    apbRead(12'h4, rd); check("R5 busy during reset", rd, 32'h1);
    apbRead(12'h8, rd); check("R7 dbg reads reset value", rd, 32'h0);
    apbWrite(12'h8, 32'h0, err);
    check("R6 write refused", {31'd0, err}, 32'h1);
    waitCycles(20);
    apbRead(12'h0, rd); check("R8 ctrl cleared", rd, 32'h0);
    apbRead(12'h4, rd); check("R8 busy cleared", rd, 32'h0);
    apbRead(12'h8, rd); check("R8 R6 dbg retained", rd, 32'h1);

    // R9: soft reset bit while disabled
    apbWrite(12'h0, 32'h0000_0091, err);
    check("R9 no error", {31'd0, err}, 32'h0);
    apbRead(12'h0, rd); check("R9 ordinary write", rd, 32'h0000_0090);
    apbRead(12'h4, rd); check("R9 enable busy only", rd, 32'h2);
    waitCycles(20);
    apbRead(12'h4, rd); check("R9 busy cleared", rd, 32'h0);

    finishRun();
  end
endmodule